// File: doc/BRIEF.md
# Hardware Return Address Stack

This block holds the return addresses of nested subroutine calls and interrupts for an instruction sequencer. A push strobe saves a return address. A pop strobe throws away the current top, so the address saved before it becomes the top again. The top entry is always visible on an output. Software can overwrite that entry and can load the pointer directly, which lets an operating system spill and refill the stack.

The pointer counts from 0, which means empty, up to DEPTH (31 by default). The entry at the current pointer position is the top. Two sticky flags record overflow and underflow. A configuration input decides what happens at those limits:

- With the input set, the block emits a one-cycle reset request for the chip's reset controller and returns its pointer to 0. The flags stay set, because only power-on reset or a software clear removes them.
- With the input clear, the pointer saturates at the top, and pushes made there are dropped.

Top module: `ret_addr_stack`

## Requirements
- R1: While `rst_n` is low and on leaving reset, `ptr` is 0, `tos` is 0, and `full`, `unf` and `reset_req` are 0.
- R2: A push (push high, pop low, ptr_wr low) at pointer p < DEPTH-1 stores `push_addr` at slot p+1. From the next cycle, `ptr` is p+1 and `tos` shows that address.
- R3: A pop (pop high, push low, ptr_wr low) at pointer p > 0 makes `ptr` p-1. `tos` then shows the address pushed before the one discarded, or 0 when `ptr` reaches 0.
- R4: A push at pointer DEPTH-1 stores its address in slot DEPTH and sets `full`. With `ovf_rst_en` high, the pointer becomes 0 and `reset_req` is high for the next cycle. A push at pointer DEPTH with `ovf_rst_en` high stores nothing, sets `full`, zeroes the pointer and also raises `reset_req`.
- R5: With `ovf_rst_en` low, a push at pointer DEPTH-1 leaves `ptr` at DEPTH. Any push at pointer DEPTH sets `full` and changes neither the pointer nor slot DEPTH.
- R6: A pop at pointer 0 sets `unf` and leaves `ptr` at 0 with `tos` reading 0. It raises `reset_req` for one cycle exactly when `ovf_rst_en` is high.
- R7: `full` and `unf` stay set until `clr_full` or `clr_unf` respectively, or `rst_n`. An overflow or underflow in the same cycle as a clear wins, and the flag stays set.
- R8: `tos_wr` writes `tos_wdata` into the top slot when `ptr` is non-zero and push, pop and ptr_wr are all low. At pointer 0 it has no effect, and `tos` stays 0.
- R9: `ptr_wr` loads `ptr_wdata` into the pointer (values above DEPTH clamp to DEPTH). It takes priority over push, pop and tos_wr in the same cycle, and it leaves the flags and the stored entries unchanged.
- R10: A push and a pop in the same cycle, without ptr_wr, change nothing: pointer, entries and flags all keep their values, and a simultaneous tos_wr is ignored.
- R11: `reset_req` is never raised in the cycle after a cycle with `ovf_rst_en` low, and whenever it is high, `ptr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ovf_rst_en | input | 1 | 1: overflow and underflow request a reset; 0: saturate and drop |
| push | input | 1 | Push strobe |
| pop | input | 1 | Pop strobe |
| push_addr | input | AW | Return address to push |
| tos_wr | input | 1 | Software write of the top entry |
| tos_wdata | input | AW | Data for the top-entry write |
| ptr_wr | input | 1 | Software write of the pointer |
| ptr_wdata | input | PW | New pointer value |
| clr_full | input | 1 | Software clear of the full flag |
| clr_unf | input | 1 | Software clear of the underflow flag |
| tos | output | AW | Current top entry, 0 when empty |
| ptr | output | PW | Stack pointer |
| full | output | 1 | Sticky overflow flag |
| unf | output | 1 | Sticky underflow flag |
| reset_req | output | 1 | One-cycle reset request |

## Verification
The bench targets the limit cases. It checks the transition from DEPTH-1 to DEPTH under both settings of the reset enable. A design that stores the overflowing address in the wrong slot, or leaves the pointer at DEPTH instead of 0, shows a wrong `tos` or `ptr` after the overflow. It pushes repeatedly at the saturated pointer to catch a design that overwrites slot DEPTH or wraps the pointer. It pops at an empty stack to catch an underflow that wraps the pointer to DEPTH, or that raises `reset_req` with the enable clear. It also issues a clear in the same cycle as an overflow or underflow, a push and a pop together, and a pointer write together with a push, to expose a wrong priority as a flag or pointer mismatch.

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int DEPTH = 31,
  parameter int AW    = 21,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ovf_rst_en,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_addr,
  input  logic          tos_wr,
  input  logic [AW-1:0] tos_wdata,
  input  logic          ptr_wr,
  input  logic [PW-1:0] ptr_wdata,
  input  logic          clr_full,
  input  logic          clr_unf,
  output logic [AW-1:0] tos,
  output logic [PW-1:0] ptr,
  output logic          full,
  output logic          unf,
  output logic          reset_req
);

  localparam logic [PW-1:0] TOP = PW'(DEPTH);

  logic [AW-1:0] mem [0:DEPTH];
  logic [PW-1:0] ptr_q, ptr_d;
  logic          full_q, unf_q, req_q;

  wire do_push = push & ~pop & ~ptr_wr;
  wire do_pop  = pop & ~push & ~ptr_wr;
  wire empty   = (ptr_q == '0);
  wire at_top  = (ptr_q == TOP);
  wire do_tos  = tos_wr & ~push & ~pop & ~ptr_wr & ~empty;

  wire [PW-1:0] ptr_inc = ptr_q + 1'b1;
  wire [PW-1:0] ptr_dec = ptr_q - 1'b1;
  wire [PW-1:0] ptr_ld  = (ptr_wdata > TOP) ? TOP : ptr_wdata;

  wire store    = do_push & ~at_top;
  wire fills    = do_push & (at_top | (ptr_inc == TOP));
  wire ovf_kick = fills & ovf_rst_en;
  wire under    = do_pop & empty;
  wire req_d    = ovf_kick | (under & ovf_rst_en);

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_wr)
      ptr_d = ptr_ld;
    else if (do_push) begin
      if (ovf_kick)
        ptr_d = '0;
      else if (!at_top)
        ptr_d = ptr_inc;
    end else if (do_pop && !empty)
      ptr_d = ptr_dec;
  end

  for (genvar i = 0; i <= DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (store && ptr_inc == PW'(i))
        mem[i] <= push_addr;
      else if (do_tos && ptr_q == PW'(i))
        mem[i] <= tos_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      full_q <= 1'b0;
      unf_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      full_q <= fills | (full_q & ~clr_full);
      unf_q  <= under | (unf_q & ~clr_unf);
      req_q  <= req_d;
    end
  end

  assign tos       = mem[ptr_q];
  assign ptr       = ptr_q;
  assign full      = full_q;
  assign unf       = unf_q;
  assign reset_req = req_q;

endmodule

module ret_addr_stack_chk #(
  parameter int DEPTH = 31,
  parameter int AW    = 21,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ovf_rst_en,
  input logic          push,
  input logic          pop,
  input logic [AW-1:0] push_addr,
  input logic          tos_wr,
  input logic          ptr_wr,
  input logic [PW-1:0] ptr_wdata,
  input logic          clr_full,
  input logic          clr_unf,
  input logic [AW-1:0] tos,
  input logic [PW-1:0] ptr,
  input logic          full,
  input logic          unf,
  input logic          reset_req
);
  localparam logic [PW-1:0] TOP  = PW'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  assert_ptr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= TOP);

  assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !ptr_wr && ptr < LAST) |=> (ptr == $past(ptr) + 1'b1) && (tos == $past(push_addr)));

  assert_pop_shrinks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !ptr_wr && ptr != '0) |=> ptr == $past(ptr) - 1'b1);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !ptr_wr && ovf_rst_en && ptr == LAST) |=> reset_req && full && ptr == '0);

  assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !ptr_wr && !ovf_rst_en && ptr == TOP) |=> ptr == TOP && $stable(tos) && full);

  assert_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !ptr_wr && ptr == '0) |=> unf && ptr == '0 && tos == '0);

  assert_full_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr_full) |=> full);

  assert_unf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (unf && !clr_unf) |=> unf);

  assert_empty_tos_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == '0 && tos_wr && !push && !pop && !ptr_wr) |=> tos == '0);

  assert_ptr_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_wr && ptr_wdata <= TOP) |=> ptr == $past(ptr_wdata));

  assert_both_noop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !ptr_wr) |=> $stable(ptr) && $stable(tos));

  assert_req_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_rst_en |=> !reset_req);

  assert_req_ptr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> ptr == '0);
endmodule

bind ret_addr_stack ret_addr_stack_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ovf_rst_en(ovf_rst_en), .push(push), .pop(pop),
  .push_addr(push_addr), .tos_wr(tos_wr), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
  .clr_full(clr_full), .clr_unf(clr_unf), .tos(tos), .ptr(ptr), .full(full),
  .unf(unf), .reset_req(reset_req)
);

// File: tb/ret_addr_stack_tb.sv
`timescale 1ns/1ps
module ret_addr_stack_tb;
  localparam int DEPTH = 31;
  localparam int AW    = 21;
  localparam int PW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ovf_rst_en = 1'b0, push = 1'b0, pop = 1'b0, tos_wr = 1'b0, ptr_wr = 1'b0;
  logic clr_full = 1'b0, clr_unf = 1'b0;
  logic [AW-1:0] push_addr = '0, tos_wdata = '0;
  logic [PW-1:0] ptr_wdata = '0;
  logic [AW-1:0] tos;
  logic [PW-1:0] ptr;
  logic full, unf, reset_req;

  always #2 clk = ~clk;

  ret_addr_stack u_dut (
    .clk(clk), .rst_n(rst_n), .ovf_rst_en(ovf_rst_en), .push(push), .pop(pop),
    .push_addr(push_addr), .tos_wr(tos_wr), .tos_wdata(tos_wdata), .ptr_wr(ptr_wr),
    .ptr_wdata(ptr_wdata), .clr_full(clr_full), .clr_unf(clr_unf), .tos(tos),
    .ptr(ptr), .full(full), .unf(unf), .reset_req(reset_req)
  );

  int m_slot [0:DEPTH];
  int m_ptr, m_full, m_unf, m_req;
  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  string phase = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= DEPTH; i++) m_slot[i] = 0;
      m_ptr = 0; m_full = 0; m_unf = 0; m_req = 0;
    end else begin
      int set_f, set_u;
      set_f = 0; set_u = 0; m_req = 0;
      if (ptr_wr) begin
        m_ptr = (int'(ptr_wdata) > DEPTH) ? DEPTH : int'(ptr_wdata);
      end else if (push && !pop) begin
        if (m_ptr < DEPTH) begin
          m_ptr++;
          m_slot[m_ptr] = int'(push_addr);
          if (m_ptr == DEPTH) begin
            set_f = 1;
            if (ovf_rst_en) begin m_ptr = 0; m_req = 1; end
          end
        end else begin
          set_f = 1;
          if (ovf_rst_en) begin m_ptr = 0; m_req = 1; end
        end
      end else if (pop && !push) begin
        if (m_ptr > 0) m_ptr--;
        else begin set_u = 1; if (ovf_rst_en) m_req = 1; end
      end else if (tos_wr && !push && !pop && m_ptr != 0) begin
        m_slot[m_ptr] = int'(tos_wdata);
      end
      m_full = set_f ? 1 : (clr_full ? 0 : m_full);
      m_unf  = set_u ? 1 : (clr_unf ? 0 : m_unf);
    end
  end

  task automatic compare();
    int exp_tos;
    bit bad;
    bad = 1'b0;
    exp_tos = (m_ptr == 0) ? 0 : m_slot[m_ptr];
    vectors++;
    if (int'(ptr) != m_ptr) begin bad = 1; $display("FAIL %s ptr actual %0d expected %0d", phase, ptr, m_ptr); end
    if (int'(tos) != exp_tos) begin bad = 1; $display("FAIL %s tos actual %0h expected %0h", phase, tos, exp_tos); end
    if (int'(full) != m_full) begin bad = 1; $display("FAIL %s full actual %0d expected %0d", phase, full, m_full); end
    if (int'(unf) != m_unf) begin bad = 1; $display("FAIL %s unf actual %0d expected %0d", phase, unf, m_unf); end
    if (int'(reset_req) != m_req) begin bad = 1; $display("FAIL %s reset_req actual %0d expected %0d", phase, reset_req, m_req); end
    if (bad) miscompares++;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
    push = 0; pop = 0; tos_wr = 0; ptr_wr = 0; clr_full = 0; clr_unf = 0;
  endtask

  task automatic do_push(input int a);
    push = 1; push_addr = AW'(a); tick();
  endtask

  task automatic do_pop();
    pop = 1; tick();
  endtask

  task automatic load_ptr(input int v);
    ptr_wr = 1; ptr_wdata = PW'(v); tick();
  endtask

  initial begin
    @(negedge clk);
    phase = "R1";
    tick(); tick();
    rst_n = 1;
    tick();

    phase = "R2";
    for (int i = 1; i <= 5; i++) do_push(32'h1000 * i + i);
    phase = "R3";
    for (int i = 0; i < 3; i++) do_pop();

    phase = "R10";
    push = 1; pop = 1; push_addr = 21'h0ABCD; tos_wr = 1; tos_wdata = 21'h1F00F; tick();

    phase = "R8";
    tos_wr = 1; tos_wdata = 21'h15555; tick();
    do_pop(); do_pop();
    tos_wr = 1; tos_wdata = 21'h0BEEF; tick();

    phase = "R6";
    ovf_rst_en = 0; do_pop(); do_pop();
    clr_unf = 1; tick();
    ovf_rst_en = 1; do_pop(); do_pop(); tick();

    phase = "R7";
    clr_unf = 1; pop = 1; tick();
    clr_unf = 1; tick();

    phase = "R4";
    load_ptr(DEPTH - 2);
    do_push(21'h11111);
    do_push(21'h1CAFE);
    tick();
    load_ptr(DEPTH);
    do_push(21'h02222);
    load_ptr(DEPTH);
    phase = "R7";
    clr_full = 1; push = 1; push_addr = 21'h03333; tick();
    clr_full = 1; tick();

    phase = "R5";
    ovf_rst_en = 0;
    load_ptr(0);
    for (int i = 0; i < DEPTH; i++) do_push(21'h100 + i);
    for (int i = 0; i < 3; i++) do_push(21'h1DEAD);
    do_pop();
    do_push(21'h07777);
    do_push(21'h08888);

    phase = "R9";
    ptr_wr = 1; ptr_wdata = 5; push = 1; push_addr = 21'h0AAAA; tick();
    ptr_wr = 1; ptr_wdata = 0; pop = 1; tick();
    ptr_wr = 1; ptr_wdata = 12; tos_wr = 1; tos_wdata = 21'h04444; tick();

    phase = "R11";
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 99);
      ovf_rst_en = (i % 97) < 50;
      push = r < 45; pop = (r >= 40 && r < 80);
      push_addr = AW'($urandom());
      tos_wr = (r % 7) == 0; tos_wdata = AW'($urandom());
      ptr_wr = r >= 97; ptr_wdata = PW'($urandom_range(0, DEPTH));
      clr_full = (r % 11) == 0; clr_unf = (r % 13) == 0;
      tick();
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule